// File: doc/BRIEF.md
# Timeslot Interchange Data Memory

This block is the storage half of a time switch. A frame holds 2**(CNT_W-1) channels and each channel timeslot lasts two clocks, so the default frame of 1024 channels spans 2048 clocks. A free-running count, cleared by an active-low frame pulse, sets the slot and the phase within the slot. A 16-bit word arriving in each timeslot goes to a location chosen by that count. The output side takes one address word per timeslot, usually from a connection store. One timeslot later it presents the word that the address names.

Each read request carries three control bits. A buffering select picks minimum-delay single buffering or frame-aligned double buffering, and it may change from one slot to the next. A message flag sends the address word itself to the output in place of the stored word. An output-enable flag is passed out as a registered drive flag, and the output holds its value while that flag is low. Each write lands in the memory half chosen by a frame-parity bit. Parity flips on every frame pulse, which keeps the two buffering schemes consistent with each other.

Top module: `tsi_data_store`

## Requirements
- R1: The count clears to 0 at a rising edge that samples `frame_n` low, and the frame-parity bit flips at the same edge. At every other edge the count adds one and wraps to 0 after 2**CNT_W-1. Parity is 0 after reset.
- R2: The edge that ends a cycle with an even count (the first cycle of a slot) samples `rd_addr`, `msg_en`, `out_en` and `dbl_buf`. Values that are present only during odd-count cycles have no effect.
- R3: A request captured at the edge that samples count 2j-2 drives its output at the edge that samples count 2j, two clocks later. `rd_data` and `drive_en` change at no edge that samples an odd count.
- R4: The edge that ends an odd-count cycle (count 2i+1) captures `wr_data` as the word of channel i. The next edge writes it. Values that are present only during even-count cycles have no effect.
- R5: With `dbl_buf`=0, output slot j takes source channel i from the low CNT_W-1 bits of the address word, and the higher bits are ignored. The word comes from the same frame when j >= i+2. Otherwise it comes from the previous frame, and that includes the last channel switched to slot 0.
- R6: With `dbl_buf`=1, output slot j in frame F gives channel i's word from frame F-1, for every pair (i, j).
- R7: The buffering select is taken per request, so neighbouring slots may use different schemes within one frame.
- R8: With `msg_en`=1 the output is the whole 16-bit captured address word.
- R9: `drive_en` takes the captured `out_en` at the output edge of its slot. While `drive_en` is 0, `rd_data` keeps its previous value.
- R10: After reset `rd_data` is 0 and `drive_en` is 0. The first output edge, with no request captured yet, keeps both at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame pulse, active low, sampled on the rising edge |
| wr_data | input | WORD_W | Incoming channel word |
| rd_addr | input | WORD_W | Read address word, also the message word |
| msg_en | input | 1 | Send the address word to the output |
| out_en | input | 1 | Requested output drive for the slot |
| dbl_buf | input | 1 | 1 selects double buffering for this slot |
| rd_data | output | WORD_W | Outgoing channel word |
| drive_en | output | 1 | Registered drive flag for an external tri-state buffer |

## Verification
The bench covers every source and destination pair in both buffering schemes. It alternates the scheme from slot to slot, so a half-selection error shows up as a word one frame too old or too new. The hard pairs are those where the destination comes one slot after the source and where the last channel goes to slot 0. A design without write-to-read forwarding returns a word two frames old for the second case. Junk on every input during the phase that should ignore it exposes a capture on the wrong edge, and a frame pulse on an odd count exposes a count that is not cleared, because every later output then moves by one clock. Message slots, disabled slots and the hold that follows them check that the output is not refreshed from memory while the drive flag is off.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef struct packed {
    logic msg;
    logic oe;
    logic dbl;
  } rd_ctl_t;

  // A source channel written at count 2*src+2 counts as fresh for a read at
  // rd_count when that write lies strictly before the read.
  function automatic logic src_is_fresh(int unsigned src_ch, int unsigned rd_count);
    return rd_count >= (2 * src_ch + 4);
  endfunction

  // Location inside the store: half bit above the channel index.
  function automatic logic pick_half(logic dbl, logic fresh, logic parity);
    if (dbl) return ~parity;
    return fresh ? parity : ~parity;
  endfunction

endpackage

// File: rtl/tsi_frame_counter.sv
module tsi_frame_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  output logic [CNT_W-1:0] count,
  output logic             parity,
  output logic             head
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      parity <= 1'b0;
    end else if (!frame_n) begin
      count  <= '0;
      parity <= ~parity;
    end else begin
      count  <= count + 1'b1;
    end
  end

  assign head = ~count[0];

endmodule

// File: rtl/tsi_write_stage.sv
module tsi_write_stage #(
  parameter int CNT_W  = 11,
  parameter int WORD_W = 16,
  localparam int CH_W  = CNT_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head,
  input  logic [CH_W-1:0]   slot,
  input  logic              parity,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_en,
  output logic [CNT_W-1:0]  wr_loc,
  output logic [WORD_W-1:0] wr_word
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      wr_loc  <= '0;
      wr_word <= '0;
    end else if (!head) begin
      armed   <= 1'b1;
      wr_loc  <= {parity, slot};
      wr_word <= wr_data;
    end
  end

  assign wr_en = armed & head;

endmodule

// File: rtl/tsi_word_store.sv
module tsi_word_store #(
  parameter int LOC_W  = 11,
  parameter int WORD_W = 16,
  localparam int DEPTH = 1 << LOC_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [DEPTH];
  logic              collide;

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_loc] <= wr_word;
  end

  assign collide = wr_en && (wr_loc == rd_loc);
  assign rd_word = collide ? wr_word : cells[rd_loc];

endmodule

// File: rtl/tsi_data_store.sv
module tsi_data_store #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] rd_addr,
  input  logic              msg_en,
  input  logic              out_en,
  input  logic              dbl_buf,
  output logic [WORD_W-1:0] rd_data,
  output logic              drive_en
);
  import tsi_pkg::*;

  localparam int CH_W = CNT_W - 1;

  logic [CNT_W-1:0]  count;
  logic              parity;
  logic              head;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_loc;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] addr_q;
  rd_ctl_t           ctl_q;
  logic [CH_W-1:0]   rd_idx;
  logic              fresh;
  logic [CNT_W-1:0]  rd_loc;
  logic [WORD_W-1:0] rd_word;

  // named events for the checker
  logic cap_msg;
  logic cap_oe;

  tsi_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n),
    .count(count), .parity(parity), .head(head)
  );

  tsi_write_stage #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .head(head), .slot(count[CNT_W-1:1]),
    .parity(parity), .wr_data(wr_data),
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_word(wr_word)
  );

  assign rd_idx = addr_q[CH_W-1:0];
  assign fresh  = src_is_fresh(32'(rd_idx), 32'(count));
  assign rd_loc = {pick_half(ctl_q.dbl, fresh, parity), rd_idx};

  tsi_word_store #(.LOC_W(CNT_W), .WORD_W(WORD_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_loc(wr_loc), .wr_word(wr_word),
    .rd_loc(rd_loc), .rd_word(rd_word)
  );

  // Output edge and request capture share the slot-head edge: the output
  // uses the request taken one slot earlier, then the new one is latched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      ctl_q    <= '0;
      rd_data  <= '0;
      drive_en <= 1'b0;
    end else if (head) begin
      drive_en <= ctl_q.oe;
      if (ctl_q.oe) rd_data <= ctl_q.msg ? addr_q : rd_word;
      addr_q   <= rd_addr;
      ctl_q    <= '{msg: msg_en, oe: out_en, dbl: dbl_buf};
    end
  end

  assign cap_msg = ctl_q.msg;
  assign cap_oe  = ctl_q.oe;

endmodule

// File: rtl/tsi_data_store_chk.sv
module tsi_data_store_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n,
  input logic              head,
  input logic [CNT_W-1:0]  count,
  input logic              parity,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] addr_q,
  input logic              cap_msg,
  input logic              cap_oe,
  input logic [WORD_W-1:0] rd_data,
  input logic              drive_en
);

  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> count == '0);

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> count == $past(count) + CNT_W'(1));

  a_r1_parity_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> parity != $past(parity));

  a_r1_parity_keep: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> $stable(parity));

  a_r3_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    !head |=> $stable(rd_data) && $stable(drive_en));

  a_r4_write_word: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(!head) |-> wr_word == $past(wr_data));

  a_r8_message: assert property (@(posedge clk) disable iff (!rst_n)
    head && cap_msg && cap_oe |=> rd_data == $past(addr_q));

  a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
    head |=> drive_en == $past(cap_oe));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> $stable(rd_data));

endmodule

bind tsi_data_store tsi_data_store_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .head(head), .count(count),
  .parity(parity), .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data),
  .addr_q(addr_q), .cap_msg(cap_msg), .cap_oe(cap_oe),
  .rd_data(rd_data), .drive_en(drive_en)
);

// File: tb/tsi_data_store_bench.sv
module tsi_data_store_bench;
  localparam int CW    = 5;
  localparam int NCH   = 1 << (CW - 1);
  localparam int LAST  = (1 << CW) - 1;
  localparam int FINAL = 36;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [15:0] wr_data;
  logic [15:0] rd_addr;
  logic        msg_en, out_en, dbl_buf;
  logic [15:0] rd_data;
  logic        drive_en;

  always #10 clk = ~clk;

  tsi_data_store #(.WORD_W(16), .CNT_W(CW)) u_tsi_data_store (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .wr_data(wr_data),
    .rd_addr(rd_addr), .msg_en(msg_en), .out_en(out_en), .dbl_buf(dbl_buf),
    .rd_data(rd_data), .drive_en(drive_en)
  );

  int errs = 0, checks = 0;
  int mc = 0, fr = 0;
  bit done = 0;
  logic [15:0] pend_data [NCH];
  logic        pend_en   [NCH];
  string       pend_tag  [NCH];
  logic [15:0] last_out = '0;

  function automatic logic [15:0] word_in(int f, int i);
    return {f[7:0], 4'hC, i[3:0]};
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s frame=%0d count=%0d actual=%h expected=%h", tag, fr, mc, act, exp);
    end
  endtask

  task automatic issue(int fo, int j);
    int src = (fo + j) % NCH;
    bit dbl = bit'(((fo / 16) + j) % 2);
    bit me  = (fo < 2) || (fo >= FINAL) || (j == 5 && fo % 4 == 0);
    bit oe  = (fo < 2) || (fo >= FINAL) || !(j == 9 && fo % 3 == 0);
    logic [15:0] a = {8'(fo * 7 + 3), 4'(j), 4'(src)};
    rd_addr = a; msg_en = me; out_en = oe; dbl_buf = dbl;
    if (oe) begin
      if (me)                          last_out = a;
      else if (dbl || j < src + 2)     last_out = word_in(fo - 1, src);
      else                             last_out = word_in(fo, src);
    end
    pend_data[j] = last_out;
    pend_en[j]   = oe;
    if (fo >= FINAL)  pend_tag[j] = "R1 clear";
    else if (!oe)     pend_tag[j] = "R9 hold";
    else if (me)      pend_tag[j] = "R8 message";
    else if (dbl)     pend_tag[j] = "R6 R7 double";
    else              pend_tag[j] = "R5 R7 single";
  endtask

  task automatic step();
    bit mid = (fr == FINAL) && (mc == 13);
    if (mc % 2 == 1) begin
      int j = mc / 2;
      chk(pend_tag[j], rd_data, pend_data[j]);
      chk({pend_tag[j], " R9 flag"}, {15'b0, drive_en}, {15'b0, pend_en[j]});
    end else begin
      int j = (mc / 2 + NCH - 1) % NCH;
      chk("R3 steady", rd_data, pend_data[j]);
    end
    frame_n = (mc == LAST || mid) ? 1'b0 : 1'b1;
    if (mc % 2 == 0) begin
      int j = (mc / 2 + 1) % NCH;
      issue((j == 0) ? fr + 1 : fr, j);
      wr_data = 16'hA5A5 ^ 16'(mc * 97 + fr);   // R4: junk outside capture phase
    end else begin
      wr_data = word_in(fr, mc / 2);
      rd_addr = 16'(fr * 1231 + mc * 77);        // R2: junk outside capture phase
      msg_en  = ((fr + mc) % 3 == 0);
      out_en  = ((fr + mc) % 2 == 1);
      dbl_buf = (mc % 4 == 1);
    end
    @(negedge clk);
    if (!frame_n) begin
      if (mid) begin
        int cur = mc / 2;
        pend_data[NCH-1] = pend_data[cur];     pend_en[NCH-1] = pend_en[cur];
        pend_tag[NCH-1]  = "R1 clear";
        pend_data[0]     = pend_data[cur + 1]; pend_en[0] = pend_en[cur + 1];
        pend_tag[0]      = "R1 clear";
      end
      mc = 0;
      fr++;
    end else begin
      mc++;
    end
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) begin
      pend_data[k] = '0; pend_en[k] = 1'b0; pend_tag[k] = "R10 first";
    end
    rst_n = 1'b0; frame_n = 1'b1; wr_data = '0; rd_addr = '0;
    msg_en = 1'b0; out_en = 1'b0; dbl_buf = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset data", rd_data, 16'h0000);
    chk("R10 reset flag", {15'b0, drive_en}, 16'h0000);
    rst_n = 1'b1;
    while (fr < FINAL + 3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule